// File: doc/BRIEF.md
# Cascaded register access node

This block is the host-side register port of one device in a chain of identical devices. A 15-bit expansion bus carries an 8-bit data byte in its low bits and a 7-bit register address in its high bits. The host drives this bus into the first device. Each later device receives a registered copy from the device before it. Every device holds a 73-entry register file of bytes. A device reads or writes its own registers only when the global program-enable and its own chip enable are both low.

The handshake is self-timed. The first device turns the host's active-low data strobe into an active-high chain strobe. Every device registers that strobe once and passes it on. The strobe leaving the last device is the host reply, so the host never needs to know how long the chain is. On a read, the addressed device places the selected register's contents on a read-data path. That path runs down the chain next to the strobe, so the data at the last device is valid when the reply rises. A device used on its own returns read data on its own data lines, with an output enable for the board's three-state driver. In that case program-enable and chip enable are tied together.

The chain position is a parameter: alone, first, middle or last.

Top module: `casc_reg_node`

## Requirements
- R1: After synchronous reset, every register reads as zero, and `strb_out` and `rdat_out` are both zero.
- R2: A write stores `x_in[7:0]` into the register selected by `x_in[14:8]`. It needs `rd_wr`=0 and `prog_n`=0 and `ce_n`=0, and it happens once, at the first cycle the strobe seen by the device is high. The strobe seen by a first or alone device is the inverse of `ds_n`; for any other device it is `strb_in`. A later read of the same address returns the written byte.
- R3: A write while `prog_n` is high, or while `ce_n` is high, leaves every register unchanged.
- R4: Addresses 73 to 127 are unmapped. Writes to them change no register, and reads from them return zero.
- R5: `strb_out` equals the device's strobe input one cycle earlier. In a chain of N devices, the reply at the last device therefore rises N cycles after `ds_n` falls, and falls N cycles after `ds_n` rises.
- R6: `x_out` equals `x_in` one cycle earlier.
- R7: On a read with `rd_wr`=1, the last device's `rdat_out` holds the addressed register of whichever device in the chain is selected, in the cycles where `strb_out` is high. Reading leaves register contents unchanged.
- R8: A device in the alone position raises `x_dat_oe` only while `prog_n`=0, `ce_n`=0 and `rd_wr`=1. It presents the read byte on `x_dat_out` while the reply is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 15 | Expansion bus: address [14:8], data [7:0], from the host or from the previous device |
| ce_n | input | 1 | Active-low chip enable for this device |
| ds_n | input | 1 | Active-low host data strobe (used by a first or alone device) |
| prog_n | input | 1 | Active-low global program-enable |
| rd_wr | input | 1 | 1 = read, 0 = write |
| strb_in | input | 1 | Chain strobe from the previous device |
| rdat_in | input | 8 | Read data from the previous device |
| x_out | output | 15 | Registered expansion bus to the next device |
| strb_out | output | 1 | Registered chain strobe; the host reply at the last device |
| rdat_out | output | 8 | Read data toward the next device; the final read output at the last device |
| x_dat_out | output | 8 | Read data for the host bus in the alone position |
| x_dat_oe | output | 1 | Drive enable for the host data lines in the alone position |

## Verification
A three-device chain gets a full sweep of writes, to every address of every device, with a byte that depends on both the device and the address. A full read sweep follows. A wrong address field, a register landing in the wrong device, or aliasing of unmapped addresses onto real registers would each show up as a mismatched byte. Writes made with program-enable high, or with no chip enable low, overwrite a known byte with a different one, which separates "ignored" from "stored". The reply latency is counted on every access, and this pins down a single stage per device for both strobe edges. A device in the alone position repeats the sweep, and there the output enable is checked on both reads and writes.

// File: rtl/casc_node_pkg.sv
package casc_node_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;
    localparam int BUS_W  = DATA_W + ADDR_W;
    localparam int NREG   = 73;

    typedef enum logic [1:0] {
        POS_ALONE = 2'd0,
        POS_FIRST = 2'd1,
        POS_MID   = 2'd2,
        POS_LAST  = 2'd3
    } chain_pos_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } xbus_t;

    function automatic logic sources_strobe(chain_pos_e p);
        return (p == POS_ALONE) || (p == POS_FIRST);
    endfunction

    function automatic logic is_mapped(logic [ADDR_W-1:0] a);
        return a <= ADDR_W'(NREG - 1);
    endfunction

endpackage

// File: rtl/casc_fwd_stage.sv
module casc_fwd_stage
    import casc_node_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  strb_src,
    input  xbus_t x_src,
    output logic  strb_q,
    output xbus_t x_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            strb_q <= 1'b0;
            x_q    <= '0;
        end else begin
            strb_q <= strb_src;
            x_q    <= x_src;
        end
    end

    assert_strb_delay_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(strb_q) |-> $past(strb_src));

    assert_fwd_bus_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> x_q == $past(x_src));

endmodule

// File: rtl/casc_access_ctl.sv
module casc_access_ctl
    import casc_node_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strb_eff,
    input  logic prog_n,
    input  logic ce_n,
    input  logic rd_wr,
    output logic wr_pulse,
    output logic rd_load
);

    logic strb_prev;
    logic selected;

    always_ff @(posedge clk) begin
        if (rst) strb_prev <= 1'b0;
        else     strb_prev <= strb_eff;
    end

    assign selected = ~prog_n & ~ce_n;
    assign wr_pulse = selected & ~rd_wr & strb_eff & ~strb_prev;
    assign rd_load  = selected & rd_wr & strb_eff;

endmodule

// File: rtl/casc_regfile.sv
module casc_regfile
    import casc_node_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we && is_mapped(waddr)) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = is_mapped(raddr) ? mem[raddr] : '0;

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (we && is_mapped(waddr)) |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/casc_reg_node.sv
module casc_reg_node
    import casc_node_pkg::*;
#(
    parameter chain_pos_e POS = POS_ALONE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  x_in,
    input  logic              ce_n,
    input  logic              ds_n,
    input  logic              prog_n,
    input  logic              rd_wr,
    input  logic              strb_in,
    input  logic [DATA_W-1:0] rdat_in,
    output logic [BUS_W-1:0]  x_out,
    output logic              strb_out,
    output logic [DATA_W-1:0] rdat_out,
    output logic [DATA_W-1:0] x_dat_out,
    output logic              x_dat_oe
);

    localparam logic HEAD = sources_strobe(POS);

    xbus_t             bus_in;
    xbus_t             bus_q;
    logic              strb_eff;
    logic              wr_pulse;
    logic              rd_load;
    logic [DATA_W-1:0] rf_rdata;
    logic [DATA_W-1:0] rd_src;
    logic [DATA_W-1:0] rd_q;

    assign bus_in   = xbus_t'(x_in);
    assign strb_eff = HEAD ? ~ds_n : strb_in;
    assign rd_src   = HEAD ? '0 : rdat_in;

    casc_fwd_stage u_stage (
        .clk      (clk),
        .rst      (rst),
        .strb_src (strb_eff),
        .x_src    (bus_in),
        .strb_q   (strb_out),
        .x_q      (bus_q)
    );

    casc_access_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .strb_eff (strb_eff),
        .prog_n   (prog_n),
        .ce_n     (ce_n),
        .rd_wr    (rd_wr),
        .wr_pulse (wr_pulse),
        .rd_load  (rd_load)
    );

    casc_regfile u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_pulse),
        .waddr (bus_in.addr),
        .wdata (bus_in.data),
        .raddr (bus_in.addr),
        .rdata (rf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)          rd_q <= '0;
        else if (rd_load) rd_q <= rf_rdata;
        else              rd_q <= rd_src;
    end

    assign x_out     = BUS_W'(bus_q);
    assign rdat_out  = rd_q;
    assign x_dat_out = rd_q;
    assign x_dat_oe  = (POS == POS_ALONE) & ~prog_n & ~ce_n & rd_wr;

    assert_unmapped_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_load && !is_mapped(bus_in.addr)) |=> rdat_out == '0);

endmodule

// File: tb/tb_casc_reg_node.sv
module tb_casc_reg_node;
    import casc_node_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NDEV = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // chain host side
    logic [14:0] host_x = '0;
    logic [NDEV-1:0] ce_n = '1;
    logic ds_n = 1'b1, prog_n = 1'b1, rd_wr = 1'b0;
    logic [14:0] x0, x1, x2;
    logic s0, s1, s2;
    logic [7:0] r0, r1, r2;
    logic [7:0] d0, d1, d2;
    logic o0, o1, o2;

    // alone device side
    logic [14:0] a_x = '0;
    logic a_sel_n = 1'b1, a_ds_n = 1'b1, a_rd = 1'b0;
    logic [14:0] a_xo;
    logic a_s;
    logic [7:0] a_r, a_d;
    logic a_oe;

    casc_reg_node #(.POS(POS_FIRST)) u_first (
        .clk(clk), .rst(rst), .x_in(host_x), .ce_n(ce_n[0]), .ds_n(ds_n),
        .prog_n(prog_n), .rd_wr(rd_wr), .strb_in(1'b0), .rdat_in(8'h00),
        .x_out(x0), .strb_out(s0), .rdat_out(r0), .x_dat_out(d0), .x_dat_oe(o0));

    casc_reg_node #(.POS(POS_MID)) u_mid (
        .clk(clk), .rst(rst), .x_in(x0), .ce_n(ce_n[1]), .ds_n(ds_n),
        .prog_n(prog_n), .rd_wr(rd_wr), .strb_in(s0), .rdat_in(r0),
        .x_out(x1), .strb_out(s1), .rdat_out(r1), .x_dat_out(d1), .x_dat_oe(o1));

    casc_reg_node #(.POS(POS_LAST)) dut (
        .clk(clk), .rst(rst), .x_in(x1), .ce_n(ce_n[2]), .ds_n(ds_n),
        .prog_n(prog_n), .rd_wr(rd_wr), .strb_in(s1), .rdat_in(r1),
        .x_out(x2), .strb_out(s2), .rdat_out(r2), .x_dat_out(d2), .x_dat_oe(o2));

    casc_reg_node #(.POS(POS_ALONE)) u_alone (
        .clk(clk), .rst(rst), .x_in(a_x), .ce_n(a_sel_n), .ds_n(a_ds_n),
        .prog_n(a_sel_n), .rd_wr(a_rd), .strb_in(1'b0), .rdat_in(8'h00),
        .x_out(a_xo), .strb_out(a_s), .rdat_out(a_r), .x_dat_out(a_d), .x_dat_oe(a_oe));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int dev, int addr);
        return 8'((addr * 7 + dev * 31 + 5) % 256);
    endfunction

    // dev = NDEV means no chip enable asserted
    task automatic chain_access(input int dev, input bit rd, input bit prog,
                                input int addr, input logic [7:0] data,
                                output logic [7:0] got);
        int lat;
        @(negedge clk);
        host_x = {7'(addr), data};
        ce_n   = '1;
        if (dev < NDEV) ce_n[dev] = 1'b0;
        prog_n = ~prog;
        rd_wr  = rd;
        @(negedge clk);
        ds_n = 1'b0;
        lat = 0;
        while (!s2 && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == NDEV, "R5 reply rise latency", lat, NDEV);
        chk(x2 == {7'(addr), data}, "R6 forwarded bus", int'(x2), int'({7'(addr), data}));
        got = r2;
        ds_n = 1'b1;
        lat = 0;
        while (s2 && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == NDEV, "R5 reply fall latency", lat, NDEV);
        ce_n = '1;
        prog_n = 1'b1;
    endtask

    task automatic alone_access(input bit rd, input int addr, input logic [7:0] data,
                                output logic [7:0] got);
        int lat;
        @(negedge clk);
        a_x = {7'(addr), data};
        a_sel_n = 1'b0;
        a_rd = rd;
        @(negedge clk);
        chk(a_oe == rd, "R8 output enable", a_oe, rd);
        a_ds_n = 1'b0;
        lat = 0;
        while (!a_s && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 1, "R5 alone reply latency", lat, 1);
        got = a_d;
        a_ds_n = 1'b1;
        @(negedge clk);
        a_sel_n = 1'b1;
        @(negedge clk);
        chk(a_oe == 1'b0, "R8 enable off when deselected", a_oe, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        logic [7:0] exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(s2 == 1'b0, "R1 reply low after reset", s2, 0);
        chk(r2 == 8'h00, "R1 read path zero after reset", r2, 0);
        for (int d = 0; d < NDEV; d++) begin
            chain_access(d, 1'b1, 1'b1, 10 + d, 8'h00, got);
            chk(got == 8'h00, "R1 register zero after reset", got, 0);
        end

        // R2 / R4 write sweep of every address of every device
        for (int d = 0; d < NDEV; d++)
            for (int a = 0; a < 128; a++)
                chain_access(d, 1'b0, 1'b1, a, pat(d, a), got);

        // R3 ignored writes: program-enable high, then no chip enable
        chain_access(0, 1'b0, 1'b0, 5, ~pat(0, 5), got);
        chain_access(1, 1'b0, 1'b0, 72, ~pat(1, 72), got);
        chain_access(NDEV, 1'b0, 1'b1, 6, ~pat(2, 6), got);
        chain_access(0, 1'b1, 1'b1, 5, 8'h00, got);
        chk(got == pat(0, 5), "R3 write with program-enable high ignored", got, pat(0, 5));
        chain_access(1, 1'b1, 1'b1, 72, 8'h00, got);
        chk(got == pat(1, 72), "R3 write with program-enable high ignored", got, pat(1, 72));
        chain_access(2, 1'b1, 1'b1, 6, 8'h00, got);
        chk(got == pat(2, 6), "R3 write without chip enable ignored", got, pat(2, 6));

        // R7 / R4 read sweep
        for (int d = 0; d < NDEV; d++)
            for (int a = 0; a < 128; a++) begin
                chain_access(d, 1'b1, 1'b1, a, 8'h00, got);
                exp = (a < 73) ? pat(d, a) : 8'h00;
                if (a < 73) chk(got == exp, "R7 chain readback", got, exp);
                else        chk(got == exp, "R4 unmapped read zero", got, exp);
            end
        // R7 reading is non-destructive
        chain_access(0, 1'b1, 1'b1, 40, 8'h00, got);
        chk(got == pat(0, 40), "R7 second read unchanged", got, pat(0, 40));

        // R8 alone device sweep
        for (int a = 0; a < 128; a++)
            alone_access(1'b0, a, pat(3, a), got);
        for (int a = 0; a < 128; a++) begin
            alone_access(1'b1, a, 8'h00, got);
            exp = (a < 73) ? pat(3, a) : 8'h00;
            chk(got == exp, "R8 alone readback on data lines", got, exp);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule